// File: doc/BRIEF.md
# USB Serial Receive Path

This block sits behind a clock and data recovery stage in a USB device transceiver. It takes one recovered line bit per strobe, together with a flag that marks a single-ended-zero bit time, and turns the stream into bytes for the serial interface engine. It hunts for the SYNC pattern on the raw line levels and then NRZI-decodes the payload. It also removes stuff bits, assembles bytes least significant bit first, and recognizes the end-of-packet sequence. The engine sees the usual status flags: receive-active, receive-valid and receive-error.

A separate path reports the two-bit state of the bus pins. During normal operation this value is registered in the interface clock domain. While the transceiver is suspended, the pin levels go straight through to the output with no register.

A reset input may be asserted asynchronously. Inside the block it is released in step with the clock.

Top module: `usb_rx_path`

## Requirements
- R1: After reset, rx_active, rx_valid and rx_error are 0.
- R2: Line levels are given as rx_j (1 = J, 0 = K). The block is hunting and sees, on consecutive strobed non-SE0 bits, the levels K J K J K K. rx_active then goes to 1 in the cycle after the strobe of the last K. A run with fewer than two K-J alternations before the K K does not start a packet.
- R3: A strobed data bit decodes to 1 when the level equals the previous level and to 0 when it differs. For the first data bit, the previous level is the final K of SYNC. Bytes are assembled least significant bit first. rx_data is presented with a one-cycle rx_valid pulse in the cycle after the strobe of the byte's eighth bit, and only while rx_active is 1.
- R4: A decoded 0 that directly follows six consecutive decoded 1s is dropped and does not enter a byte. The count of consecutive 1s starts at zero with the first data bit.
- R5: A decoded 1 after six consecutive decoded 1s is a stuffing violation. It raises rx_error, and no byte is delivered from the rest of that packet. After the next end of packet, the block hunts again.
- R6: Two SE0 strobes followed by a strobed J end a packet, and rx_active is 0 in the cycle after that J strobe. rx_error is raised instead when the received data bit count at that point is not a multiple of 8.
- R7: rx_error is a one-cycle pulse issued on the same registered timing as rx_valid, with rx_active still 1. rx_active is 0 in the following cycle.
- R8: Line inputs presented while bit_stb is 0 have no effect on the delivered bytes or flags.
- R9: line_state bit 0 follows line_dp and bit 1 follows line_dm (00 SE0, 01 J, 10 K, 11 SE1). With suspend_n = 1 it is registered, so it changes one clock edge after the pins do.
- R10: With suspend_n = 0, line_state is a combinational copy of {line_dm, line_dp}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bit_stb | input | 1 | One recovered bit time is present this cycle |
| rx_j | input | 1 | Recovered line level, 1 = J, 0 = K |
| rx_se0 | input | 1 | Recovered bit is single-ended zero |
| line_dp | input | 1 | Positive data pin level |
| line_dm | input | 1 | Negative data pin level |
| suspend_n | input | 1 | 0 = suspended, line state passes through |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | rx_data holds a new byte this cycle |
| rx_active | output | 1 | A packet is being received |
| rx_error | output | 1 | Receive error pulse |
| line_state | output | 2 | {DM, DP} bus state |

## Verification
The bench sends packets with mixed bit values to check NRZI decoding and byte order. It sends runs of 0xFF, which force stuff bits, to separate correct unstuffing from bytes that are shifted by one bit. It sends a run of seven identical levels to confirm that a violation is flagged and the packet is discarded, and that the following packet still gets through. Other cases cover a packet ending on a partial byte, and a near-miss SYNC that must not open a packet. A mode that drives conflicting levels between strobes shows that gated cycles are ignored. Finally, the pin state is toggled around a clock edge with and without suspend, which separates the registered path from the pass-through path.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_RECV  = 2'd1,
    ST_ERRW  = 2'd2,
    ST_DRAIN = 2'd3
  } rx_state_e;

  localparam logic LVL_J = 1'b1;
  localparam logic LVL_K = 1'b0;
endpackage

// File: rtl/usb_rx_sync_hunt.sv
module usb_rx_sync_hunt #(
  parameter int SYNC_PAIRS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hunt_en,
  input  logic bit_stb,
  input  logic rx_j,
  input  logic rx_se0,
  output logic sop_hit
);
  import usb_rx_pkg::*;

  localparam int HIST_W = 2 * SYNC_PAIRS + 2;

  // index 0 = newest level; K K at the end, alternating J/K before it
  function automatic logic [HIST_W-1:0] sync_pattern();
    logic [HIST_W-1:0] p;
    for (int i = 0; i < HIST_W; i++) begin
      p[i] = (i >= 2) && (i % 2 == 0);
    end
    return p;
  endfunction

  localparam logic [HIST_W-1:0] PATTERN = sync_pattern();

  logic [HIST_W-1:0] hist_q, hist_d;
  logic [HIST_W-1:0] hist_shift;

  assign hist_shift = {hist_q[HIST_W-2:0], rx_j};

  always_comb begin
    hist_d = hist_q;
    if (!hunt_en || (bit_stb && rx_se0)) begin
      hist_d = '1;
    end else if (bit_stb) begin
      hist_d = hist_shift;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '1;
    else        hist_q <= hist_d;
  end

  assign sop_hit = hunt_en && bit_stb && !rx_se0 && (hist_shift == PATTERN);

  // R2: a packet can only open on a K level
  a_r2_sop_on_k: assert property (@(posedge clk) disable iff (!rst_n)
    sop_hit |-> (rx_j == LVL_K));
endmodule

// File: rtl/usb_rx_decode.sv
module usb_rx_decode #(
  parameter int STUFF_LIM = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic dec_en,
  input  logic rx_j,
  output logic bit_ok,
  output logic bit_val,
  output logic stuff_viol
);
  import usb_rx_pkg::*;

  localparam int ONES_W = $clog2(STUFF_LIM + 1);

  logic              prev_q, prev_d;
  logic [ONES_W-1:0] ones_q, ones_d;
  logic              at_lim;

  assign bit_val    = (rx_j == prev_q);
  assign at_lim     = (ones_q == ONES_W'(STUFF_LIM));
  assign bit_ok     = dec_en && !at_lim;
  assign stuff_viol = dec_en && at_lim && bit_val;

  always_comb begin
    prev_d = prev_q;
    ones_d = ones_q;
    if (restart) begin
      prev_d = LVL_K;
      ones_d = '0;
    end else if (dec_en) begin
      prev_d = rx_j;
      if (at_lim || !bit_val) ones_d = '0;
      else                    ones_d = ones_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= LVL_J;
      ones_q <= '0;
    end else begin
      prev_q <= prev_d;
      ones_q <= ones_d;
    end
  end

  // R4: the run counter never passes the stuffing limit
  a_r4_ones_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= ONES_W'(STUFF_LIM));
endmodule

// File: rtl/usb_rx_ctrl.sv
module usb_rx_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              rx_j,
  input  logic              rx_se0,
  input  logic              sop_hit,
  input  logic              bit_ok,
  input  logic              bit_val,
  input  logic              stuff_viol,
  output logic              hunt_en,
  output logic              dec_en,
  output logic              dec_restart,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_active,
  output logic              rx_error
);
  import usb_rx_pkg::*;

  localparam int CNT_W = $clog2(DATA_W);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  bcnt_q, bcnt_d;
  logic [1:0]        se0_q, se0_d;
  logic              drain_q, drain_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              valid_q, valid_d;
  logic              err_q, err_d;
  logic [DATA_W-1:0] shifted;

  assign shifted = {bit_val, shreg_q[DATA_W-1:1]};

  always_comb begin
    state_d     = state_q;
    bcnt_d      = bcnt_q;
    se0_d       = se0_q;
    drain_d     = drain_q;
    shreg_d     = shreg_q;
    data_d      = data_q;
    valid_d     = 1'b0;
    err_d       = 1'b0;
    dec_en      = 1'b0;
    dec_restart = 1'b0;
    case (state_q)
      ST_HUNT: begin
        if (sop_hit) begin
          state_d     = ST_RECV;
          bcnt_d      = '0;
          se0_d       = '0;
          dec_restart = 1'b1;
        end
      end
      ST_RECV: begin
        if (bit_stb) begin
          if (rx_se0) begin
            if (se0_q != 2'd2) se0_d = se0_q + 1'b1;
          end else if (se0_q != 2'd0) begin
            se0_d = '0;
            if (se0_q == 2'd2 && rx_j == LVL_J && bcnt_q == '0) begin
              state_d = ST_HUNT;
            end else begin
              err_d   = 1'b1;
              drain_d = 1'b0;
              state_d = ST_ERRW;
            end
          end else begin
            dec_en = 1'b1;
            if (stuff_viol) begin
              err_d   = 1'b1;
              drain_d = 1'b1;
              state_d = ST_ERRW;
            end else if (bit_ok) begin
              shreg_d = shifted;
              if (bcnt_q == CNT_W'(DATA_W - 1)) begin
                bcnt_d  = '0;
                data_d  = shifted;
                valid_d = 1'b1;
              end else begin
                bcnt_d = bcnt_q + 1'b1;
              end
            end
          end
        end
      end
      ST_ERRW: begin
        se0_d   = (bit_stb && rx_se0) ? 2'd1 : 2'd0;
        state_d = drain_q ? ST_DRAIN : ST_HUNT;
      end
      default: begin
        if (bit_stb) begin
          if (rx_se0)              se0_d = 2'd1;
          else if (se0_q != 2'd0) begin
            se0_d   = '0;
            state_d = ST_HUNT;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      bcnt_q  <= '0;
      se0_q   <= '0;
      drain_q <= 1'b0;
      shreg_q <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bcnt_q  <= bcnt_d;
      se0_q   <= se0_d;
      drain_q <= drain_d;
      shreg_q <= shreg_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  assign hunt_en   = (state_q == ST_HUNT);
  assign rx_active = (state_q == ST_RECV) || (state_q == ST_ERRW);
  assign rx_data   = data_q;
  assign rx_valid  = valid_q;
  assign rx_error  = err_q;

  // R3: bytes only appear inside a packet, as single-cycle pulses
  a_r3_valid_in_active: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_active);
  a_r3_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R7: error shows with active high, then active drops
  a_r7_err_with_active: assert property (@(posedge clk) disable iff (!rst_n)
    rx_error |-> rx_active);
  a_r7_err_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rx_error |=> !rx_active);
  // R5: no byte delivered alongside an error
  a_r5_no_byte_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    rx_error |-> !rx_valid);
endmodule

// File: rtl/usb_rx_linestate.sv
module usb_rx_linestate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       suspend_n,
  input  logic       line_dp,
  input  logic       line_dm,
  output logic [1:0] line_state
);
  logic [1:0] pins;
  logic [1:0] ls_q;

  assign pins = {line_dm, line_dp};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ls_q <= 2'b00;
    else        ls_q <= pins;
  end

  assign line_state = suspend_n ? ls_q : pins;
endmodule

// File: rtl/usb_rx_path.sv
module usb_rx_path #(
  parameter int DATA_W     = 8,
  parameter int STUFF_LIM  = 6,
  parameter int SYNC_PAIRS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              rx_j,
  input  logic              rx_se0,
  input  logic              line_dp,
  input  logic              line_dm,
  input  logic              suspend_n,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_active,
  output logic              rx_error,
  output logic [1:0]        line_state
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  logic       hunt_en, dec_en, dec_restart, sop_hit;
  logic       bit_ok, bit_val, stuff_viol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  usb_rx_sync_hunt #(.SYNC_PAIRS(SYNC_PAIRS)) u_hunt (
    .clk(clk), .rst_n(rst_i_n), .hunt_en(hunt_en), .bit_stb(bit_stb),
    .rx_j(rx_j), .rx_se0(rx_se0), .sop_hit(sop_hit)
  );

  usb_rx_decode #(.STUFF_LIM(STUFF_LIM)) u_dec (
    .clk(clk), .rst_n(rst_i_n), .restart(dec_restart), .dec_en(dec_en),
    .rx_j(rx_j), .bit_ok(bit_ok), .bit_val(bit_val), .stuff_viol(stuff_viol)
  );

  usb_rx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_i_n), .bit_stb(bit_stb), .rx_j(rx_j),
    .rx_se0(rx_se0), .sop_hit(sop_hit), .bit_ok(bit_ok), .bit_val(bit_val),
    .stuff_viol(stuff_viol), .hunt_en(hunt_en), .dec_en(dec_en),
    .dec_restart(dec_restart), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_active(rx_active), .rx_error(rx_error)
  );

  usb_rx_linestate u_ls (
    .clk(clk), .rst_n(rst_i_n), .suspend_n(suspend_n), .line_dp(line_dp),
    .line_dm(line_dm), .line_state(line_state)
  );
endmodule

// File: tb/usb_rx_path_test.sv
module usb_rx_path_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_stb = 1'b0, rx_j = 1'b1, rx_se0 = 1'b0;
  logic       line_dp = 1'b1, line_dm = 1'b0, suspend_n = 1'b1;
  logic [7:0] rx_data;
  logic       rx_valid, rx_active, rx_error;
  logic [1:0] line_state;

  int checks = 0, errors = 0;
  logic [7:0] got_b [0:31];
  int got_n = 0, err_n = 0, bad_after = 0, act_cycles = 0;
  logic prev_err = 1'b0;
  logic noise = 1'b0;
  logic [7:0] tx_b [0:15];
  int tx_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_rx_path uut (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_j(rx_j), .rx_se0(rx_se0),
    .line_dp(line_dp), .line_dm(line_dm), .suspend_n(suspend_n),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_active(rx_active),
    .rx_error(rx_error), .line_state(line_state)
  );

  // monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid && got_n < 32) begin got_b[got_n] = rx_data; got_n++; end
      if (rx_error) err_n++;
      if (prev_err && rx_active) bad_after++;
      if (rx_active) act_cycles++;
      prev_err = rx_error;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    got_n = 0; err_n = 0; bad_after = 0; act_cycles = 0;
  endtask

  task automatic drive(input logic se0, input logic lvl);
    @(negedge clk);
    bit_stb = 1'b1; rx_se0 = se0; rx_j = lvl;
    @(negedge clk);
    bit_stb = 1'b0;
    if (noise) begin rx_j = ~lvl; rx_se0 = 1'b1; end
  endtask

  task automatic send_sync();
    for (int i = 0; i < 3; i++) drive(0, 1);
    for (int i = 0; i < 3; i++) begin drive(0, 0); drive(0, 1); end
    drive(0, 0); drive(0, 0);
  endtask

  task automatic send_eop();
    drive(1, 0); drive(1, 0); drive(0, 1);
    for (int i = 0; i < 4; i++) drive(0, 1);
  endtask

  // NRZI + stuffing of tx_b, then extra raw data bits
  task automatic send_payload(input int nextra, input logic [7:0] extra);
    logic lvl;
    int ones;
    lvl = 1'b0; ones = 0;
    for (int k = 0; k < tx_n + 1; k++) begin
      for (int b = 0; b < 8; b++) begin
        logic d;
        if (k == tx_n && b >= nextra) break;
        d = (k == tx_n) ? extra[b] : tx_b[k][b];
        if (d) ones++; else begin lvl = ~lvl; ones = 0; end
        drive(0, lvl);
        if (ones == 6) begin lvl = ~lvl; drive(0, lvl); ones = 0; end
      end
    end
  endtask

  task automatic check_bytes(input string req);
    chk(got_n == tx_n, req, got_n, tx_n);
    for (int i = 0; i < tx_n; i++)
      if (i < got_n) chk(got_b[i] == tx_b[i], req, got_b[i], tx_b[i]);
  endtask

  task automatic t_reset();
    chk(rx_active == 0, "R1 active", rx_active, 0);
    chk(rx_valid == 0, "R1 valid", rx_valid, 0);
    chk(rx_error == 0, "R1 error", rx_error, 0);
  endtask

  task automatic t_basic();
    clear_mon();
    tx_b[0] = 8'hA5; tx_b[1] = 8'h3C; tx_b[2] = 8'h01; tx_n = 3;
    send_sync();
    chk(rx_active == 1, "R2 active after sync", rx_active, 1);
    send_payload(0, 8'h00);
    send_eop();
    check_bytes("R3 bytes");
    chk(err_n == 0, "R6 clean eop", err_n, 0);
    chk(rx_active == 0, "R6 active low", rx_active, 0);
  endtask

  task automatic t_stuff();
    clear_mon();
    tx_b[0] = 8'hFF; tx_b[1] = 8'hFF; tx_b[2] = 8'h7E; tx_n = 3;
    send_sync(); send_payload(0, 8'h00); send_eop();
    check_bytes("R4 unstuffed bytes");
    chk(err_n == 0, "R4 no error", err_n, 0);
  endtask

  task automatic t_gated();
    noise = 1'b1;
    clear_mon();
    tx_b[0] = 8'h5A; tx_b[1] = 8'hFF; tx_n = 2;
    send_sync(); send_payload(0, 8'h00); send_eop();
    noise = 1'b0; rx_j = 1'b1; rx_se0 = 1'b0;
    check_bytes("R8 gated cycles ignored");
    chk(err_n == 0, "R8 no error", err_n, 0);
  endtask

  task automatic t_violation();
    clear_mon();
    send_sync();
    for (int i = 0; i < 7; i++) drive(0, 0);
    for (int i = 0; i < 10; i++) drive(0, i[0]);
    chk(rx_active == 0, "R5 discarding", rx_active, 0);
    send_eop();
    chk(err_n == 1, "R5 error count", err_n, 1);
    chk(got_n == 0, "R5 no bytes", got_n, 0);
    chk(bad_after == 0, "R7 active after error", bad_after, 0);
    clear_mon();
    tx_b[0] = 8'hC3; tx_n = 1;
    send_sync(); send_payload(0, 8'h00); send_eop();
    check_bytes("R5 recovery");
  endtask

  task automatic t_partial();
    clear_mon();
    tx_b[0] = 8'h12; tx_n = 1;
    send_sync(); send_payload(3, 8'h05); send_eop();
    check_bytes("R6 full byte before partial");
    chk(err_n == 1, "R6 partial byte error", err_n, 1);
    chk(bad_after == 0, "R7 active after error", bad_after, 0);
  endtask

  task automatic t_nosync();
    clear_mon();
    drive(0, 1); drive(0, 1); drive(0, 1);
    drive(0, 0); drive(0, 1); drive(0, 0); drive(0, 0);
    for (int i = 0; i < 8; i++) drive(0, i[1]);
    chk(act_cycles == 0, "R2 near-miss sync", act_cycles, 0);
    chk(got_n == 0, "R2 no bytes", got_n, 0);
  endtask

  task automatic t_linestate();
    @(negedge clk);
    chk(line_state == 2'b01, "R9 J encoding", line_state, 1);
    line_dp = 1'b0; line_dm = 1'b1;
    #1;
    chk(line_state == 2'b01, "R9 registered hold", line_state, 1);
    @(negedge clk);
    chk(line_state == 2'b10, "R9 K encoding", line_state, 2);
    suspend_n = 1'b0;
    line_dp = 1'b1; line_dm = 1'b1;
    #1;
    chk(line_state == 2'b11, "R10 pass-through SE1", line_state, 3);
    line_dp = 1'b0; line_dm = 1'b0;
    #1;
    chk(line_state == 2'b00, "R10 pass-through SE0", line_state, 0);
    suspend_n = 1'b1; line_dp = 1'b1; line_dm = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_basic();
    t_stuff();
    t_gated();
    t_violation();
    t_partial();
    t_nosync();
    t_linestate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule